// File: doc/BRIEF.md
# Real-Time Clock Status and Interrupt Register

This block is the status word of a real-time clock. It sits on a simple 32-bit register port and holds the interrupt enables and the sticky event flags for seven event sources. The sources are the once-per-second tick, a single-counter legacy alarm, two calendar alarms, two stopwatch alarms and the periodic interrupt. The counting and compare logic elsewhere in the clock raises a one-cycle strobe for each event. The matching flag is set and stays set until software clears it.

Each flag is write-one-to-clear, and it shares the word with plain read-write enable bits. Software that reads the word and writes it straight back therefore clears every pending event and keeps its enables unchanged. Software that writes zeros in the flag positions changes only the enables. Two interrupt outputs leave the block. The tick interrupt follows the tick flag gated by its enable. The alarm interrupt is the OR of every other flag, each gated by its own enable.

Top module: `rtc_status_reg`

## Requirements
- R1: After reset, the word at the register offset reads 0x0000_0000, and both irq_tick and irq_alarm are low.
- R2: A one-cycle strobe on ev_strobe[i] sets the flag for source i by the following clock edge. The source indices and flag bit positions are: 0 legacy alarm at bit 0, 1 tick at bit 1, 2 calendar alarm 1 at bit 4, 3 calendar alarm 2 at bit 6, 4 stopwatch alarm 1 at bit 8, 5 stopwatch alarm 2 at bit 10, 6 periodic at bit 13. The flag stays set after the strobe ends.
- R3: A write to the register offset with a 1 in a flag position clears that flag. A 0 in a flag position leaves that flag unchanged.
- R4: The enable bits are read-write, and each write to the offset replaces all of them. The enable positions are: legacy at bit 2, tick at bit 3, calendar 1 at bit 5, calendar 2 at bit 7, stopwatch 1 at bit 9, stopwatch 2 at bit 11, periodic alarm at bit 14. The periodic count enable is at bit 15.
- R5: A strobe and a clearing write that reach the same flag in the same cycle leave the flag set.
- R6: irq_tick is high exactly when the tick flag (bit 1) and the tick enable (bit 3) are both set.
- R7: irq_alarm is high exactly when at least one of the six non-tick flags is set together with its own enable. The periodic count enable (bit 15) has no effect on either interrupt.
- R8: Bit 12 and bits 16 to 31 always read as zero, and writes to them have no effect.
- R9: A write to any other address leaves the register unchanged, and a read at any other address returns zero.
- R10: Reading the word and writing the same value back clears all pending flags and keeps every enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset that clears every flag and enable |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| ev_strobe | input | 7 | One-cycle event strobes, by source index |
| irq_tick | output | 1 | Tick interrupt |
| irq_alarm | output | 1 | Combined alarm interrupt |

## Verification
On every cycle, the assertions check the life of each flag: a strobe sets it, a lone clearing write drops it, and with neither it holds. They also check that an enable changes only on a write at the register offset and then takes the written value. Reading the word at the offset must never show a reserved bit. Only the bench scenarios show the exact bit positions seen at the port, the write-back idiom, decoding of other addresses, and how each flag and enable pair reaches the right interrupt output.

// File: rtl/rtcsr_pkg.sv
package rtcsr_pkg;
   localparam int NUM_SRC   = 7;
   localparam int SRC_TICK  = 1;
   localparam int CNT_EN_POS = 15;

   typedef logic [NUM_SRC-1:0] src_vec_t;

   function automatic int flag_pos(input int idx);
      case (idx)
         0: return 0;
         1: return 1;
         2: return 4;
         3: return 6;
         4: return 8;
         5: return 10;
         default: return 13;
      endcase
   endfunction

   function automatic int enable_pos(input int idx);
      case (idx)
         0: return 2;
         1: return 3;
         2: return 5;
         3: return 7;
         4: return 9;
         5: return 11;
         default: return 14;
      endcase
   endfunction
endpackage

// File: rtl/rtcsr_flag.sv
module rtcsr_flag #(
   parameter bit SET_WINS = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   logic q_next;

   generate
      if (SET_WINS) begin : g_set_first
         always_comb q_next = set_i | (q & ~clr_i);

         assert_set_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            set_i |=> q);
      end else begin : g_clear_first
         always_comb q_next = (q | set_i) & ~clr_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= q_next;
   end

   // R3: a lone clearing write drops the flag
   assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !q);
   // R2: with neither a strobe nor a clear, the flag holds
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !set_i) |=> $stable(q));
endmodule

// File: rtl/rtcsr_port.sv
module rtcsr_port
   import rtcsr_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          DATA_W     = 32,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h08
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  src_vec_t          flags,
   output src_vec_t          clr,
   output src_vec_t          en,
   output logic              cnt_en
);
   logic     hit;
   logic     wr_hit;
   src_vec_t wr_en_bits;
   logic [DATA_W-1:0] word;

   assign hit    = (bus_addr == REG_OFFSET);
   assign wr_hit = hit & bus_wr;

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
         wr_en_bits[i] = bus_wdata[enable_pos(i)];
         clr[i]        = wr_hit & bus_wdata[flag_pos(i)];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en     <= '0;
         cnt_en <= 1'b0;
      end else if (wr_hit) begin
         en     <= wr_en_bits;
         cnt_en <= bus_wdata[CNT_EN_POS];
      end
   end

   always_comb begin
      word = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         word[flag_pos(i)]   = flags[i];
         word[enable_pos(i)] = en[i];
      end
      word[CNT_EN_POS] = cnt_en;
   end

   assign bus_rdata = hit ? word : '0;

   // R4: a write at the offset loads the enables from the write data
   assert_en_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hit |=> (en == $past(wr_en_bits)) && (cnt_en == $past(bus_wdata[CNT_EN_POS])));
   // R9: no write at the offset, no enable change
   assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_hit |=> $stable(en) && $stable(cnt_en));
   // R8: reserved positions never read as one
   assert_reserved_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rdata[12] == 1'b0) && (bus_rdata[DATA_W-1:16] == '0));
endmodule

// File: rtl/rtcsr_irq.sv
module rtcsr_irq
   import rtcsr_pkg::*;
#(
   parameter int TICK_IDX = SRC_TICK
) (
   input  logic     clk,
   input  logic     rst_n,
   input  src_vec_t flags,
   input  src_vec_t en,
   output logic     irq_tick,
   output logic     irq_alarm
);
   src_vec_t live;
   src_vec_t alarm_mask;

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) alarm_mask[i] = (i != TICK_IDX);
   end

   assign live      = flags & en;
   assign irq_tick  = live[TICK_IDX];
   assign irq_alarm = |(live & alarm_mask);

   // R7: a rising alarm interrupt needs a new flag or a new enable
   assert_alarm_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_alarm) |-> ((flags & ~$past(flags)) != '0) || ((en & ~$past(en)) != '0));
   // R6: a rising tick interrupt needs the tick flag or enable to rise
   assert_tick_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_tick) |-> ($rose(flags[TICK_IDX]) || $rose(en[TICK_IDX])));
endmodule

// File: rtl/rtc_status_reg.sv
module rtc_status_reg
   import rtcsr_pkg::*;
#(
   parameter int          ADDR_W     = 8,
   parameter int          DATA_W     = 32,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h08,
   parameter bit          SET_WINS   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_SRC-1:0] ev_strobe,
   output logic              irq_tick,
   output logic              irq_alarm
);
   localparam int ALIGN = DATA_W / 8;

   generate
      if (DATA_W < 16) begin : g_bad_width
         $error("rtc_status_reg: DATA_W must hold bit 15");
      end
      if ((REG_OFFSET % ALIGN) != 0) begin : g_bad_offset
         $error("rtc_status_reg: REG_OFFSET must be word aligned");
      end
   endgenerate

   src_vec_t flags;
   src_vec_t clr;
   src_vec_t en;
   logic     cnt_en;

   rtcsr_port #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_OFFSET(REG_OFFSET)
   ) u_port (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .flags(flags),
      .clr(clr), .en(en), .cnt_en(cnt_en)
   );

   generate
      for (genvar g = 0; g < NUM_SRC; g++) begin : g_flag
         rtcsr_flag #(.SET_WINS(SET_WINS)) u_flag (
            .clk(clk), .rst_n(rst_n), .set_i(ev_strobe[g]),
            .clr_i(clr[g]), .q(flags[g])
         );
      end
   endgenerate

   rtcsr_irq #(.TICK_IDX(SRC_TICK)) u_irq (
      .clk(clk), .rst_n(rst_n), .flags(flags), .en(en),
      .irq_tick(irq_tick), .irq_alarm(irq_alarm)
   );
endmodule

// File: tb/tb_rtc_status_reg.sv
`timescale 1ns/1ps
module tb_rtc_status_reg;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = 8'h08;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [6:0]  ev_strobe = '0;
   logic        irq_tick, irq_alarm;

   int checks = 0;
   int errors = 0;

   int fpos [7] = '{0, 1, 4, 6, 8, 10, 13};
   int epos [7] = '{2, 3, 5, 7, 9, 11, 14};

   always #5 clk = ~clk;

   rtc_status_reg dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_strobe(ev_strobe),
      .irq_tick(irq_tick), .irq_alarm(irq_alarm)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0; bus_addr = 8'h08;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
      bus_addr = 8'h08;
      #1;
   endtask

   task automatic strobe(input logic [6:0] s);
      @(negedge clk);
      ev_strobe = s;
      @(negedge clk);
      ev_strobe = '0;
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(8'h08, d);
      check("R1 word", d, 32'h0);
      check("R1 irqs", {30'h0, irq_tick, irq_alarm}, 32'h0);
   endtask

   task automatic t_each_source();
      logic [31:0] d;
      for (int i = 0; i < 7; i++) begin
         strobe(7'(1 << i));
         repeat (2) @(negedge clk);
         rd(8'h08, d);
         check("R2 flag set and sticky", d, 32'(1) << fpos[i]);
         wr(8'h08, 32'(1) << fpos[i]);
         rd(8'h08, d);
         check("R3 flag cleared by one", d, 32'h0);
      end
   endtask

   task automatic t_write_zero();
      logic [31:0] d;
      strobe(7'h7F);
      wr(8'h08, 32'h0000_0010);
      rd(8'h08, d);
      check("R3 zero leaves other flags", d, 32'h2543);
      wr(8'h08, 32'h2543);
      rd(8'h08, d);
      check("R3 all cleared", d, 32'h0);
   endtask

   task automatic t_enables();
      logic [31:0] d;
      wr(8'h08, 32'h0000_CAAC);
      rd(8'h08, d);
      check("R4 enables written", d, 32'h0000_CAAC);
      wr(8'h08, 32'h0000_0220);
      rd(8'h08, d);
      check("R4 enables replaced", d, 32'h0000_0220);
      wr(8'h08, 32'h0);
   endtask

   task automatic t_collision();
      logic [31:0] d;
      strobe(7'h04);
      @(negedge clk);
      ev_strobe = 7'h05; bus_wr = 1'b1; bus_wdata = 32'h0000_0011;
      @(negedge clk);
      ev_strobe = '0; bus_wr = 1'b0; bus_wdata = '0;
      rd(8'h08, d);
      check("R5 set wins over clear", d, 32'h0000_0011);
      wr(8'h08, 32'h11);
   endtask

   task automatic t_tick_irq();
      strobe(7'h02);
      check("R6 flag without enable", {31'h0, irq_tick}, 32'h0);
      wr(8'h08, 32'h0000_0008);
      check("R6 tick irq high", {30'h0, irq_tick, irq_alarm}, 32'h2);
      wr(8'h08, 32'h0000_000A);
      check("R6 tick irq low after clear", {31'h0, irq_tick}, 32'h0);
      wr(8'h08, 32'h0);
   endtask

   task automatic t_alarm_irq();
      for (int i = 0; i < 7; i++) begin
         if (i == 1) continue;
         wr(8'h08, 32'(1) << epos[i]);
         check("R7 enable alone no irq", {31'h0, irq_alarm}, 32'h0);
         strobe(7'(1 << i));
         check("R7 alarm irq from source", {30'h0, irq_tick, irq_alarm}, 32'h1);
         wr(8'h08, (32'(1) << fpos[i]) | (32'(1) << epos[i]));
         check("R7 alarm irq drops", {31'h0, irq_alarm}, 32'h0);
      end
      strobe(7'h7D);
      wr(8'h08, 32'h0000_8000);
      check("R7 count enable gives no irq", {30'h0, irq_tick, irq_alarm}, 32'h0);
      wr(8'h08, 32'h2551);
   endtask

   task automatic t_reserved();
      logic [31:0] d;
      wr(8'h08, 32'hFFFF_1000);
      rd(8'h08, d);
      check("R8 reserved ignored", d, 32'h0);
   endtask

   task automatic t_other_addr();
      logic [31:0] d;
      strobe(7'h01);
      wr(8'h0C, 32'hFFFF_FFFF);
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h08, d);
      check("R9 other writes ignored", d, 32'h1);
      rd(8'h0C, d);
      check("R9 other read zero", d, 32'h0);
      wr(8'h08, 32'h1);
   endtask

   task automatic t_writeback();
      logic [31:0] d;
      wr(8'h08, 32'h0000_C0A4);
      strobe(7'h55);
      rd(8'h08, d);
      check("R10 snapshot", d, 32'h0000_E1B5);
      wr(8'h08, d);
      rd(8'h08, d);
      check("R10 flags cleared enables kept", d, 32'h0000_C0A4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_each_source();
      t_write_zero();
      t_enables();
      t_collision();
      t_tick_irq();
      t_alarm_irq();
      t_reserved();
      t_other_addr();
      t_writeback();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule